// File: doc/BRIEF.md
# Integer Execute Unit with Opcode and Function Decode

This block is the integer execute stage of a small 32-bit RISC core. Each cycle it receives a 6-bit primary opcode, a 6-bit function code, a shift-amount field, the two register operands (called rs and rt below) and a 16-bit immediate. It decodes these fields, extends the immediate the way the instruction class requires, selects the operation and returns a 32-bit result. It also returns a signed-overflow flag and an illegal-instruction flag for the surrounding pipeline to act on.

Operations cover register-register arithmetic and logic, their immediate forms, load-upper-immediate, signed set-less-than, and logical and arithmetic shifts by a constant or a register amount. The register file, memory access, branches, multiply/divide and pipeline control sit outside the block. A parameter picks either a purely combinational output or a single registered output stage. A second parameter picks how the shifter is built: with the language operators or as an explicit logarithmic stage chain.

Top module: `alu_exec`

## Requirements
- R1: With opcode 0, function code 32 returns rs+rt, 34 returns rs-rt, 33 returns rs+rt and 35 returns rs-rt, all modulo 2^32.
- R2: With opcode 0, function code 36 returns rs AND rt, 37 returns OR, 38 returns XOR and 39 returns NOR. NOR with rs equal to zero returns the bitwise complement of rt.
- R3: The overflow flag is 1 only when function 32, function 34 or opcode 8 produces a signed two's-complement overflow. Function codes 33 and 35, opcode 9 and every non-arithmetic operation return 0 on the flag.
- R4: Function code 42 (opcode 0) and opcode 10 return 1 when the first operand is less than the second under signed comparison, and 0 otherwise.
- R5: For opcodes 8, 9 and 10 the immediate is sign-extended from bit 15 before use.
- R6: For opcodes 12 (AND), 13 (OR) and 14 (XOR) the immediate is zero-extended before it is combined with rs.
- R7: Opcode 15 returns the immediate in bits 31:16 and zero in bits 15:0, whatever rs holds.
- R8: With opcode 0, function code 0 shifts rt left logically, 2 shifts it right logically and 3 shifts it right arithmetically, each by the shift-amount field.
- R9: With opcode 0, function codes 4, 6 and 7 do the same three shifts of rt by the low 5 bits of rs. The shift-amount field is then ignored.
- R10: Any opcode other than 0, 8, 9, 10, 12, 13, 14 and 15, or any opcode-0 function code not listed in R1, R2, R4, R8 and R9, sets the illegal flag, returns a zero result and clears the overflow flag.
- R11: With the registered variant, outputs show the decode of the inputs one clock edge later, and an active-low reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register and the checks |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Primary opcode field |
| funct | input | 6 | Function field, decoded when opcode is 0 |
| shamt | input | SHAMT_W (5) | Constant shift amount |
| rs_val | input | XLEN (32) | First register operand |
| rt_val | input | XLEN (32) | Second register operand, also the shifted value |
| imm | input | IMM_W (16) | Immediate field |
| result | output | XLEN (32) | Operation result |
| overflow | output | 1 | Signed overflow of a trapping add or subtract |
| illegal | output | 1 | Opcode/function combination not recognised |

## Verification
The bench builds two copies side by side with XLEN 32 and IMM_W 16. One is combinational and uses the staged logarithmic shifter. The other registers its outputs and uses the operator-based shifter. Every directed vector therefore checks both shifter variants at shift amounts 0, 4 and 31, and checks that the registered copy lags by exactly one edge. Holding the registered copy in reset at the start checks its cleared state. Having both variants in one build lets a fault in either shifter, or in the register stage, show up as a difference from the hand-computed value.

// File: rtl/alu_pkg.sv
package alu_pkg;

   localparam int OPC_W = 6;
   localparam int FN_W  = 6;

   // primary opcodes
   localparam logic [OPC_W-1:0] OPC_REG   = 6'd0;
   localparam logic [OPC_W-1:0] OPC_ADDI  = 6'd8;
   localparam logic [OPC_W-1:0] OPC_ADDIU = 6'd9;
   localparam logic [OPC_W-1:0] OPC_SLTI  = 6'd10;
   localparam logic [OPC_W-1:0] OPC_ANDI  = 6'd12;
   localparam logic [OPC_W-1:0] OPC_ORI   = 6'd13;
   localparam logic [OPC_W-1:0] OPC_XORI  = 6'd14;
   localparam logic [OPC_W-1:0] OPC_LUI   = 6'd15;

   // function codes under OPC_REG
   localparam logic [FN_W-1:0] FN_SLL  = 6'd0;
   localparam logic [FN_W-1:0] FN_SRL  = 6'd2;
   localparam logic [FN_W-1:0] FN_SRA  = 6'd3;
   localparam logic [FN_W-1:0] FN_SLLV = 6'd4;
   localparam logic [FN_W-1:0] FN_SRLV = 6'd6;
   localparam logic [FN_W-1:0] FN_SRAV = 6'd7;
   localparam logic [FN_W-1:0] FN_ADD  = 6'd32;
   localparam logic [FN_W-1:0] FN_ADDU = 6'd33;
   localparam logic [FN_W-1:0] FN_SUB  = 6'd34;
   localparam logic [FN_W-1:0] FN_SUBU = 6'd35;
   localparam logic [FN_W-1:0] FN_AND  = 6'd36;
   localparam logic [FN_W-1:0] FN_OR   = 6'd37;
   localparam logic [FN_W-1:0] FN_XOR  = 6'd38;
   localparam logic [FN_W-1:0] FN_NOR  = 6'd39;
   localparam logic [FN_W-1:0] FN_SLT  = 6'd42;

   typedef enum logic [3:0] {
      ALU_NONE,
      ALU_ADD,
      ALU_SUB,
      ALU_SLT,
      ALU_AND,
      ALU_OR,
      ALU_XOR,
      ALU_NOR,
      ALU_LUI,
      ALU_SHL,
      ALU_SHR,
      ALU_SAR
   } alu_op_e;

   typedef struct packed {
      alu_op_e op;
      logic    use_imm;
      logic    imm_sext;
      logic    shamt_var;
      logic    ovf_en;
      logic    illegal;
   } alu_ctrl_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
   import alu_pkg::*;
(
   input  logic [OPC_W-1:0] opcode,
   input  logic [FN_W-1:0]  funct,
   output alu_ctrl_t        ctrl
);

   always_comb begin
      ctrl = '{op: ALU_NONE, use_imm: 1'b0, imm_sext: 1'b0,
               shamt_var: 1'b0, ovf_en: 1'b0, illegal: 1'b0};
      case (opcode)
         OPC_REG: begin
            case (funct)
               FN_ADD:  begin ctrl.op = ALU_ADD; ctrl.ovf_en = 1'b1; end
               FN_ADDU: ctrl.op = ALU_ADD;
               FN_SUB:  begin ctrl.op = ALU_SUB; ctrl.ovf_en = 1'b1; end
               FN_SUBU: ctrl.op = ALU_SUB;
               FN_SLT:  ctrl.op = ALU_SLT;
               FN_AND:  ctrl.op = ALU_AND;
               FN_OR:   ctrl.op = ALU_OR;
               FN_XOR:  ctrl.op = ALU_XOR;
               FN_NOR:  ctrl.op = ALU_NOR;
               FN_SLL:  ctrl.op = ALU_SHL;
               FN_SRL:  ctrl.op = ALU_SHR;
               FN_SRA:  ctrl.op = ALU_SAR;
               FN_SLLV: begin ctrl.op = ALU_SHL; ctrl.shamt_var = 1'b1; end
               FN_SRLV: begin ctrl.op = ALU_SHR; ctrl.shamt_var = 1'b1; end
               FN_SRAV: begin ctrl.op = ALU_SAR; ctrl.shamt_var = 1'b1; end
               default: ctrl.illegal = 1'b1;
            endcase
         end
         OPC_ADDI: begin
            ctrl.op = ALU_ADD; ctrl.use_imm = 1'b1;
            ctrl.imm_sext = 1'b1; ctrl.ovf_en = 1'b1;
         end
         OPC_ADDIU: begin
            ctrl.op = ALU_ADD; ctrl.use_imm = 1'b1; ctrl.imm_sext = 1'b1;
         end
         OPC_SLTI: begin
            ctrl.op = ALU_SLT; ctrl.use_imm = 1'b1; ctrl.imm_sext = 1'b1;
         end
         OPC_ANDI: begin ctrl.op = ALU_AND; ctrl.use_imm = 1'b1; end
         OPC_ORI:  begin ctrl.op = ALU_OR;  ctrl.use_imm = 1'b1; end
         OPC_XORI: begin ctrl.op = ALU_XOR; ctrl.use_imm = 1'b1; end
         OPC_LUI:  begin ctrl.op = ALU_LUI; ctrl.use_imm = 1'b1; end
         default:  ctrl.illegal = 1'b1;
      endcase
   end

endmodule

// File: rtl/alu_operand_sel.sv
module alu_operand_sel
   import alu_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int IMM_W = 16,
   localparam int SHAMT_W = $clog2(XLEN)
)(
   input  alu_ctrl_t          ctrl,
   input  logic [XLEN-1:0]    rs_val,
   input  logic [XLEN-1:0]    rt_val,
   input  logic [IMM_W-1:0]   imm,
   input  logic [SHAMT_W-1:0] shamt,
   output logic [XLEN-1:0]    b_op,
   output logic [SHAMT_W-1:0] amt
);

   localparam int EXT_W = XLEN - IMM_W;

   logic [XLEN-1:0] imm_ext;

   always_comb begin
      if (ctrl.imm_sext)
         imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
      else
         imm_ext = {{EXT_W{1'b0}}, imm};
      b_op = ctrl.use_imm ? imm_ext : rt_val;
      amt  = ctrl.shamt_var ? rs_val[SHAMT_W-1:0] : shamt;
   end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
   parameter int XLEN   = 32,
   parameter bit BARREL = 1'b1,
   localparam int SHAMT_W = $clog2(XLEN)
)(
   input  logic [XLEN-1:0]    val,
   input  logic [SHAMT_W-1:0] amt,
   input  logic               left,
   input  logic               arith,
   output logic [XLEN-1:0]    out
);

   generate
      if (BARREL) begin : g_barrel
         logic [XLEN-1:0] lch [0:SHAMT_W];
         logic [XLEN-1:0] rch [0:SHAMT_W];
         logic            fill;

         assign fill   = arith & val[XLEN-1];
         assign lch[0] = val;
         assign rch[0] = val;

         for (genvar g = 0; g < SHAMT_W; g++) begin : g_stage
            localparam int SH = 1 << g;
            assign lch[g+1] = amt[g] ? {lch[g][XLEN-1-SH:0], {SH{1'b0}}} : lch[g];
            assign rch[g+1] = amt[g] ? {{SH{fill}}, rch[g][XLEN-1:SH]} : rch[g];
         end

         assign out = left ? lch[SHAMT_W] : rch[SHAMT_W];
      end else begin : g_operator
         always_comb begin
            if (left)
               out = val << amt;
            else if (arith)
               out = $unsigned($signed(val) >>> amt);
            else
               out = val >> amt;
         end
      end
   endgenerate

endmodule

// File: rtl/alu_core.sv
module alu_core
   import alu_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int IMM_W  = 16,
   parameter bit BARREL = 1'b1,
   localparam int SHAMT_W = $clog2(XLEN)
)(
   input  alu_ctrl_t          ctrl,
   input  logic [XLEN-1:0]    a_op,
   input  logic [XLEN-1:0]    b_op,
   input  logic [SHAMT_W-1:0] amt,
   output logic [XLEN-1:0]    res,
   output logic               ovf
);

   localparam int LOW_W = XLEN - IMM_W;

   logic            is_sub;
   logic [XLEN-1:0] b_adj;
   logic [XLEN-1:0] sum;
   logic            raw_ovf;
   logic [XLEN-1:0] sh_out;

   assign is_sub  = (ctrl.op == ALU_SUB);
   assign b_adj   = is_sub ? ~b_op : b_op;
   assign sum     = a_op + b_adj + {{(XLEN-1){1'b0}}, is_sub};
   assign raw_ovf = (a_op[XLEN-1] == b_adj[XLEN-1]) && (sum[XLEN-1] != a_op[XLEN-1]);

   alu_shifter #(.XLEN(XLEN), .BARREL(BARREL)) u_shift (
      .val   (b_op),
      .amt   (amt),
      .left  (ctrl.op == ALU_SHL),
      .arith (ctrl.op == ALU_SAR),
      .out   (sh_out)
   );

   always_comb begin
      ovf = 1'b0;
      case (ctrl.op)
         ALU_ADD, ALU_SUB: begin
            res = sum;
            ovf = ctrl.ovf_en & raw_ovf;
         end
         ALU_SLT: res = {{(XLEN-1){1'b0}}, ($signed(a_op) < $signed(b_op))};
         ALU_AND: res = a_op & b_op;
         ALU_OR:  res = a_op | b_op;
         ALU_XOR: res = a_op ^ b_op;
         ALU_NOR: res = ~(a_op | b_op);
         ALU_LUI: res = {b_op[IMM_W-1:0], {LOW_W{1'b0}}};
         ALU_SHL, ALU_SHR, ALU_SAR: res = sh_out;
         default: res = '0;
      endcase
   end

endmodule

// File: rtl/alu_exec.sv
module alu_exec
   import alu_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int IMM_W   = 16,
   parameter bit OUT_REG = 1'b0,
   parameter bit BARREL  = 1'b1,
   localparam int SHAMT_W = $clog2(XLEN)
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [OPC_W-1:0]   opcode,
   input  logic [FN_W-1:0]    funct,
   input  logic [SHAMT_W-1:0] shamt,
   input  logic [XLEN-1:0]    rs_val,
   input  logic [XLEN-1:0]    rt_val,
   input  logic [IMM_W-1:0]   imm,
   output logic [XLEN-1:0]    result,
   output logic               overflow,
   output logic               illegal
);

   // elaboration-time parameter checks
   generate
      if (XLEN != (1 << SHAMT_W)) begin : g_bad_xlen
         $error("alu_exec: XLEN must be a power of two");
      end
      if (IMM_W < 1 || IMM_W >= XLEN) begin : g_bad_imm
         $error("alu_exec: IMM_W must lie between 1 and XLEN-1");
      end
   endgenerate

   alu_ctrl_t          ctrl;
   logic [XLEN-1:0]    b_op;
   logic [SHAMT_W-1:0] amt;
   logic [XLEN-1:0]    res_c;
   logic               ovf_c;
   logic               ill_c;

   alu_decode u_dec (
      .opcode (opcode),
      .funct  (funct),
      .ctrl   (ctrl)
   );

   alu_operand_sel #(.XLEN(XLEN), .IMM_W(IMM_W)) u_opsel (
      .ctrl   (ctrl),
      .rs_val (rs_val),
      .rt_val (rt_val),
      .imm    (imm),
      .shamt  (shamt),
      .b_op   (b_op),
      .amt    (amt)
   );

   alu_core #(.XLEN(XLEN), .IMM_W(IMM_W), .BARREL(BARREL)) u_core (
      .ctrl (ctrl),
      .a_op (rs_val),
      .b_op (b_op),
      .amt  (amt),
      .res  (res_c),
      .ovf  (ovf_c)
   );

   assign ill_c = ctrl.illegal;

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               result   <= '0;
               overflow <= 1'b0;
               illegal  <= 1'b0;
            end else begin
               result   <= res_c;
               overflow <= ovf_c;
               illegal  <= ill_c;
            end
         end

         AST_REG_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (result == $past(res_c)) && (illegal == $past(ill_c))) // R11
            else $error("registered output does not follow");
      end else begin : g_comb
         assign result   = res_c;
         assign overflow = ovf_c;
         assign illegal  = ill_c;
      end
   endgenerate

   // checks on the decoded, pre-register outputs
   AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ill_c |-> (res_c == '0) && !ovf_c) // R10
      else $error("illegal op leaked a value");

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      ((opcode == OPC_REG && (funct == FN_ADDU || funct == FN_SUBU)) ||
       opcode == OPC_ADDIU || opcode == OPC_SLTI || opcode == OPC_LUI ||
       opcode == OPC_ANDI || opcode == OPC_ORI || opcode == OPC_XORI) |-> !ovf_c) // R3
      else $error("overflow from a non-trapping op");

   AST_SLT_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode == OPC_SLTI || (opcode == OPC_REG && funct == FN_SLT))
         |-> (res_c[XLEN-1:1] == '0)) // R4
      else $error("compare result not 0 or 1");

   AST_LUI_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode == OPC_LUI) |-> (res_c[XLEN-IMM_W-1:0] == '0)) // R7
      else $error("upper-immediate low half not zero");

   AST_ANDI_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode == OPC_ANDI) |-> (res_c[XLEN-1:IMM_W] == '0)) // R6
      else $error("masking immediate was sign-extended");

endmodule

// File: tb/tb_alu_exec.sv
`timescale 1ns/1ps
module tb_alu_exec;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  opcode = '0;
   logic [5:0]  funct = '0;
   logic [4:0]  shamt = '0;
   logic [31:0] rs_val = '0;
   logic [31:0] rt_val = '0;
   logic [15:0] imm = '0;

   logic [31:0] res_a, res_b;
   logic        ovf_a, ovf_b, ill_a, ill_b;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   alu_exec #(.XLEN(32), .IMM_W(16), .OUT_REG(1'b0), .BARREL(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .opcode(opcode), .funct(funct), .shamt(shamt),
      .rs_val(rs_val), .rt_val(rt_val), .imm(imm),
      .result(res_a), .overflow(ovf_a), .illegal(ill_a));

   alu_exec #(.XLEN(32), .IMM_W(16), .OUT_REG(1'b1), .BARREL(1'b0)) dut_q (
      .clk(clk), .rst_n(rst_n), .opcode(opcode), .funct(funct), .shamt(shamt),
      .rs_val(rs_val), .rt_val(rt_val), .imm(imm),
      .result(res_b), .overflow(ovf_b), .illegal(ill_b));

   task automatic compare(input string req, input string what,
                          input logic [31:0] r, input logic o, input logic i,
                          input logic [31:0] er, input logic eo, input logic ei);
      checks++;
      if (r !== er || o !== eo || i !== ei) begin
         errors++;
         $display("FAIL %s %s: got res=%h ovf=%b ill=%b, expected res=%h ovf=%b ill=%b",
                  req, what, r, o, i, er, eo, ei);
      end
   endtask

   // drive one vector, check the combinational copy, then the registered one
   task automatic run(input string req, input logic [5:0] opc, input logic [5:0] fn,
                      input logic [4:0] sh, input logic [31:0] a, input logic [31:0] b,
                      input logic [15:0] im, input logic [31:0] er,
                      input logic eo, input logic ei);
      @(negedge clk);
      opcode = opc; funct = fn; shamt = sh; rs_val = a; rt_val = b; imm = im;
      #1;
      compare(req, "comb", res_a, ovf_a, ill_a, er, eo, ei);
      @(posedge clk);
      #1;
      compare(req, "reg", res_b, ovf_b, ill_b, er, eo, ei);
   endtask

   task automatic t_reset;
      opcode = 6'd0; funct = 6'd32; rs_val = 32'd1; rt_val = 32'd1;
      repeat (3) @(negedge clk);
      compare("R11", "reset", res_b, ovf_b, ill_b, 32'h0, 1'b0, 1'b0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      compare("R11", "first edge", res_b, ovf_b, ill_b, 32'h2, 1'b0, 1'b0);
   endtask

   task automatic t_arith; // R1
      run("R1", 6'd0, 6'd32, 5'd0, 32'd5, 32'd7, 16'h0, 32'd12, 1'b0, 1'b0);
      run("R1", 6'd0, 6'd34, 5'd0, 32'd5, 32'd7, 16'h0, 32'hFFFF_FFFE, 1'b0, 1'b0);
      run("R1", 6'd0, 6'd33, 5'd0, 32'hFFFF_FFFF, 32'd1, 16'h0, 32'h0, 1'b0, 1'b0);
      run("R1", 6'd0, 6'd35, 5'd0, 32'd0, 32'd1, 16'h0, 32'hFFFF_FFFF, 1'b0, 1'b0);
   endtask

   task automatic t_overflow; // R3
      run("R3", 6'd0, 6'd32, 5'd0, 32'h7FFF_FFFF, 32'd1, 16'h0, 32'h8000_0000, 1'b1, 1'b0);
      run("R3", 6'd0, 6'd34, 5'd0, 32'h8000_0000, 32'd1, 16'h0, 32'h7FFF_FFFF, 1'b1, 1'b0);
      run("R3", 6'd8, 6'd0, 5'd0, 32'h7FFF_FFFF, 32'd0, 16'h0001, 32'h8000_0000, 1'b1, 1'b0);
      run("R3", 6'd9, 6'd0, 5'd0, 32'h7FFF_FFFF, 32'd0, 16'h0001, 32'h8000_0000, 1'b0, 1'b0);
      run("R3", 6'd0, 6'd33, 5'd0, 32'h7FFF_FFFF, 32'd1, 16'h0, 32'h8000_0000, 1'b0, 1'b0);
      run("R3", 6'd0, 6'd35, 5'd0, 32'h8000_0000, 32'd1, 16'h0, 32'h7FFF_FFFF, 1'b0, 1'b0);
   endtask

   task automatic t_logic; // R2
      run("R2", 6'd0, 6'd36, 5'd0, 32'hF0F0_F0F0, 32'hFF00_FF00, 16'h0, 32'hF000_F000, 1'b0, 1'b0);
      run("R2", 6'd0, 6'd37, 5'd0, 32'hF0F0_F0F0, 32'hFF00_FF00, 16'h0, 32'hFFF0_FFF0, 1'b0, 1'b0);
      run("R2", 6'd0, 6'd38, 5'd0, 32'hF0F0_F0F0, 32'hFF00_FF00, 16'h0, 32'h0FF0_0FF0, 1'b0, 1'b0);
      run("R2", 6'd0, 6'd39, 5'd0, 32'h0, 32'h1234_5678, 16'h0, 32'hEDCB_A987, 1'b0, 1'b0);
   endtask

   task automatic t_slt; // R4
      run("R4", 6'd0, 6'd42, 5'd0, 32'hFFFF_FFFF, 32'd1, 16'h0, 32'd1, 1'b0, 1'b0);
      run("R4", 6'd0, 6'd42, 5'd0, 32'd1, 32'hFFFF_FFFF, 16'h0, 32'd0, 1'b0, 1'b0);
      run("R4", 6'd10, 6'd0, 5'd0, 32'd5, 32'd0, 16'hFFFF, 32'd0, 1'b0, 1'b0);
      run("R4", 6'd10, 6'd0, 5'd0, 32'hFFFF_FFFE, 32'd0, 16'hFFFF, 32'd1, 1'b0, 1'b0);
   endtask

   task automatic t_sext; // R5
      run("R5", 6'd8, 6'd0, 5'd0, 32'd10, 32'd0, 16'hFFFF, 32'd9, 1'b0, 1'b0);
      run("R5", 6'd9, 6'd0, 5'd0, 32'd0, 32'd0, 16'h8000, 32'hFFFF_8000, 1'b0, 1'b0);
   endtask

   task automatic t_zext; // R6
      run("R6", 6'd12, 6'd0, 5'd0, 32'hFFFF_FFFF, 32'd0, 16'h8001, 32'h0000_8001, 1'b0, 1'b0);
      run("R6", 6'd13, 6'd0, 5'd0, 32'h0, 32'd0, 16'hFFFF, 32'h0000_FFFF, 1'b0, 1'b0);
      run("R6", 6'd14, 6'd0, 5'd0, 32'hFFFF_0000, 32'd0, 16'hFFFF, 32'hFFFF_FFFF, 1'b0, 1'b0);
   endtask

   task automatic t_lui; // R7
      run("R7", 6'd15, 6'd0, 5'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h2110, 32'h2110_0000, 1'b0, 1'b0);
   endtask

   task automatic t_shift_imm; // R8
      run("R8", 6'd0, 6'd0, 5'd31, 32'h0, 32'h1, 16'h0, 32'h8000_0000, 1'b0, 1'b0);
      run("R8", 6'd0, 6'd2, 5'd4, 32'h0, 32'h8000_0000, 16'h0, 32'h0800_0000, 1'b0, 1'b0);
      run("R8", 6'd0, 6'd3, 5'd4, 32'h0, 32'h8000_0000, 16'h0, 32'hF800_0000, 1'b0, 1'b0);
      run("R8", 6'd0, 6'd0, 5'd0, 32'h0, 32'hA5A5_5A5A, 16'h0, 32'hA5A5_5A5A, 1'b0, 1'b0);
   endtask

   task automatic t_shift_var; // R9: shamt held at a misleading value
      run("R9", 6'd0, 6'd4, 5'd9, 32'h23, 32'h1, 16'h0, 32'h8, 1'b0, 1'b0);
      run("R9", 6'd0, 6'd6, 5'd9, 32'hFFFF_FFE4, 32'hF0, 16'h0, 32'hF, 1'b0, 1'b0);
      run("R9", 6'd0, 6'd7, 5'd9, 32'd31, 32'h8000_0000, 16'h0, 32'hFFFF_FFFF, 1'b0, 1'b0);
   endtask

   task automatic t_illegal; // R10
      run("R10", 6'd63, 6'd0, 5'd0, 32'h7FFF_FFFF, 32'd1, 16'h1, 32'h0, 1'b0, 1'b1);
      run("R10", 6'd0, 6'd1, 5'd3, 32'h7FFF_FFFF, 32'd1, 16'h1, 32'h0, 1'b0, 1'b1);
      run("R10", 6'd2, 6'd32, 5'd0, 32'h7FFF_FFFF, 32'd1, 16'h1, 32'h0, 1'b0, 1'b1);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      t_reset();
      t_arith();
      t_overflow();
      t_logic();
      t_slt();
      t_sext();
      t_zext();
      t_lui();
      t_shift_imm();
      t_shift_var();
      t_illegal();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule